// File: doc/BRIEF.md
# Touch Scan Timing Sequencer

This block paces a resistive touch panel measurement. It debounces the pen-detect input and declares a touch only when the input stays high for a configured debounce window. It then runs a fixed sampling cycle for each period. The X drivers are selected and left to settle. A power-of-two burst of ADC conversions is summed and shifted down to one X value. The same steps then run for the Y axis, and one X/Y pair is presented with a one-cycle strobe.

All timing is counted in ticks of about one microsecond. A prescaler derives each tick from the system clock. The scan period and the debounce use separate step sizes, both set by parameters. The settling delay is a logarithmic code. A touch timeout counts samples that carried no usable coordinate. An average of all ones marks an invalid coordinate. After the configured number of such samples in a row, the pen is treated as lifted. The package holds reset-default constants for the timing word: period 5, debounce 0x28, settling code 7, timeout 0xA, averaging 5.

Top module: `touch_scan_seq`

## Requirements
- R1: After reset, pen_down, sample_valid, adc_req, drive_x and drive_y are all low.
- R2: While cfg_enable is low, pen_detect has no effect: pen_down and adc_req stay low.
- R3: The debounce field is in cfg_timing bits 23:16. If pen_detect is first sampled high at clock edge E0 and stays high, pen_down rises at edge E0 + D*DEB_UNIT + 1 (one tick per cycle). Any drop before that edge leaves pen_down low.
- R4: When pen_detect is sampled low while pen_down is high, pen_down, adc_req and both drive selects go low at that edge.
- R5: The settling code is in cfg_timing bits 15:8. Each axis select is held for S ticks before its first adc_req. S is 8 for code 0 and 10·2^(c-1) for codes 1 to 11. Codes above 11 act as 11.
- R6: Each sample drives X first and Y second. drive_x and drive_y are never high together.
- R7: cfg_avg_log2 = n (values above 8 act as 8) takes 2^n ADC results per axis. The reported coordinate is their sum shifted right by n bits.
- R8: The period field is in cfg_timing bits 31:24. Successive samples start P*PERIOD_UNIT ticks apart, and field value 0 means P = 256. A sample that lasts longer than the period is followed by the next one a single cycle after its end. sample_valid is a one-cycle pulse.
- R9: The touch timeout field is in cfg_timing bits 7:0. A sample whose X or Y average is all ones is not presented. When T such samples occur in a row (T > 0), pen_down drops after the T-th. T = 0 disables the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Controller enable |
| cfg_timing | input | 32 | Period, debounce, settling code, touch timeout |
| cfg_avg_log2 | input | 4 | Log2 of conversions averaged per axis |
| pen_detect | input | 1 | Pen-detect comparator level (synchronous) |
| adc_req | output | 1 | Conversion request, held while results are wanted |
| adc_valid | input | 1 | One ADC result present this cycle |
| adc_data | input | DATA_W | ADC result |
| drive_x | output | 1 | X-axis driver select |
| drive_y | output | 1 | Y-axis driver select |
| pen_down | output | 1 | Debounced touch state |
| sample_valid | output | 1 | New coordinate pair strobe |
| sample_x | output | DATA_W | Averaged X coordinate |
| sample_y | output | DATA_W | Averaged Y coordinate |

## Verification
The debounce window is swept over several field values, including zero and the reset default. A glitch one tick short separates a correct comparison from an off-by-one. The settling code is swept from 0 to 4, plus one out-of-range code on both axes, which tells the 8-tick base apart from the doubling series and checks the clamp. Averaging is swept over every select from 0 to 8 plus one clamped value, using ramps with different slopes per axis; wrong shift amounts, swapped axes or a lost first or last conversion each give a different mean. Period spacing is measured for short, zero-coded and overrun periods. Invalid all-ones bursts with a nonzero and a zero timeout separate the counted pen-up from the disabled case.

// File: rtl/tss_pkg.sv
`timescale 1ns/1ps
package tss_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_DEB, S_SETX, S_CNVX, S_SETY, S_CNVY, S_WAIT
  } scan_st_t;

  localparam int SETTLE_W     = 14;   // holds 10240 ticks
  localparam int SETTLE_TOP   = 11;   // largest settling code honoured
  localparam int FIELD_W      = 8;

  localparam logic [31:0] TIMING_DEFAULT = 32'h0528_070A;
  localparam logic [3:0]  AVG_DEFAULT    = 4'd5;

  // Logarithmic settling code to a tick count.
  function automatic logic [SETTLE_W-1:0] settle_len(input logic [FIELD_W-1:0] code);
    logic [3:0] c;
    c = (code > FIELD_W'(SETTLE_TOP)) ? 4'(SETTLE_TOP) : code[3:0];
    if (c == 4'd0) return SETTLE_W'(8);
    return SETTLE_W'(10) << (c - 4'd1);
  endfunction

endpackage

// File: rtl/tss_tick.sv
`timescale 1ns/1ps
module tss_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt, cnt_n;

  assign tick = (cnt == LAST);

  always_comb begin
    cnt_n = tick ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/tss_cfg_decode.sv
`timescale 1ns/1ps
module tss_cfg_decode
  import tss_pkg::*;
#(
  parameter int PERIOD_UNIT = 1024,
  parameter int DEB_UNIT    = 512,
  parameter int AVG_MAX     = 8,
  parameter int PW          = 19,
  parameter int DW          = 17,
  parameter int AW          = 4
) (
  input  logic [31:0]         timing,
  input  logic [3:0]          avg_raw,
  output logic [PW-1:0]       period_ticks,
  output logic [DW-1:0]       deb_ticks,
  output logic [SETTLE_W-1:0] settle_ticks,
  output logic [FIELD_W-1:0]  touch_lim,
  output logic [AW-1:0]       avg_sel
);
  logic [FIELD_W-1:0] f_per, f_deb, f_set;
  logic [FIELD_W:0]   per_steps;

  assign f_per     = timing[31:24];
  assign f_deb     = timing[23:16];
  assign f_set     = timing[15:8];
  assign touch_lim = timing[7:0];

  // A zero period field encodes the largest step count.
  assign per_steps    = {(f_per == '0), f_per};
  assign period_ticks = PW'(per_steps) * PW'(PERIOD_UNIT);
  assign deb_ticks    = DW'(f_deb) * DW'(DEB_UNIT);
  assign settle_ticks = settle_len(f_set);
  assign avg_sel      = (avg_raw > 4'(AVG_MAX)) ? AW'(AVG_MAX) : AW'(avg_raw);
endmodule

// File: rtl/tss_avg.sv
`timescale 1ns/1ps
module tss_avg #(
  parameter int DATA_W  = 16,
  parameter int AVG_MAX = 8,
  parameter int AW      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [AW-1:0]     sel,
  output logic              done,
  output logic [DATA_W-1:0] mean
);
  localparam int SUMW = DATA_W + AVG_MAX;
  localparam int CW   = AVG_MAX + 1;

  logic [SUMW-1:0] acc, acc_n, sum_w;
  logic [CW-1:0]   cnt, cnt_n, need;

  assign need  = (CW'(1) << sel) - CW'(1);
  assign sum_w = acc + SUMW'(in_data);
  assign done  = active && in_valid && (cnt == need);
  assign mean  = DATA_W'(sum_w >> sel);

  always_comb begin
    acc_n = acc;
    cnt_n = cnt;
    if (!active || done) begin
      acc_n = '0;
      cnt_n = '0;
    end else if (in_valid) begin
      acc_n = sum_w;
      cnt_n = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else begin
      acc <= acc_n;
      cnt <= cnt_n;
    end
  end

  // R7: the burst count never runs past the selected length
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= need));
  // R7: an idle averager starts each burst from an empty sum
  assert_idle_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0));
endmodule

// File: rtl/touch_scan_seq.sv
`timescale 1ns/1ps
module touch_scan_seq
  import tss_pkg::*;
#(
  parameter int TICK_DIV    = 50,
  parameter int PERIOD_UNIT = 1024,
  parameter int DEB_UNIT    = 512,
  parameter int DATA_W      = 16,
  parameter int AVG_MAX     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [31:0]       cfg_timing,
  input  logic [3:0]        cfg_avg_log2,
  input  logic              pen_detect,
  output logic              adc_req,
  input  logic              adc_valid,
  input  logic [DATA_W-1:0] adc_data,
  output logic              drive_x,
  output logic              drive_y,
  output logic              pen_down,
  output logic              sample_valid,
  output logic [DATA_W-1:0] sample_x,
  output logic [DATA_W-1:0] sample_y
);
  localparam int PW  = $clog2(256 * PERIOD_UNIT + 1);
  localparam int DW  = $clog2(255 * DEB_UNIT + 1);
  localparam int PHW = (DW > SETTLE_W) ? DW : SETTLE_W;
  localparam int AW  = $clog2(AVG_MAX + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_q = rsync[1];

  logic                tick;
  logic [PW-1:0]       period_ticks;
  logic [DW-1:0]       deb_ticks;
  logic [SETTLE_W-1:0] settle_ticks;
  logic [FIELD_W-1:0]  touch_lim;
  logic [AW-1:0]       avg_sel;
  logic                avg_done;
  logic [DATA_W-1:0]   avg_mean;

  scan_st_t           st, st_n;
  logic [PHW-1:0]     ph, ph_n;
  logic [PW-1:0]      per, per_n;
  logic               pen_q, pen_n, sv_q, sv_n;
  logic [DATA_W-1:0]  sx_q, sx_n, sy_q, sy_n, xa_q, xa_n;
  logic [FIELD_W-1:0] miss_q, miss_n;
  logic               converting, bad;

  tss_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_q), .tick(tick));

  tss_cfg_decode #(
    .PERIOD_UNIT(PERIOD_UNIT), .DEB_UNIT(DEB_UNIT), .AVG_MAX(AVG_MAX),
    .PW(PW), .DW(DW), .AW(AW)
  ) u_dec (
    .timing(cfg_timing), .avg_raw(cfg_avg_log2), .period_ticks(period_ticks),
    .deb_ticks(deb_ticks), .settle_ticks(settle_ticks), .touch_lim(touch_lim),
    .avg_sel(avg_sel)
  );

  assign converting = (st == S_CNVX) || (st == S_CNVY);

  tss_avg #(.DATA_W(DATA_W), .AVG_MAX(AVG_MAX), .AW(AW)) u_avg (
    .clk(clk), .rst_n(rst_q), .active(converting), .in_valid(adc_valid),
    .in_data(adc_data), .sel(avg_sel), .done(avg_done), .mean(avg_mean)
  );

  assign bad = (xa_q == '1) || (avg_mean == '1);

  always_comb begin
    st_n = st;  ph_n = ph;  per_n = per;
    pen_n = pen_q;  sv_n = 1'b0;
    sx_n = sx_q;  sy_n = sy_q;  xa_n = xa_q;  miss_n = miss_q;
    if (tick && (per != '0)) per_n = per - 1'b1;
    if (!cfg_enable) begin
      st_n = S_IDLE;  pen_n = 1'b0;  miss_n = '0;
    end else begin
      unique case (st)
        S_IDLE: if (pen_detect) begin
          st_n = S_DEB;  ph_n = PHW'(deb_ticks);
        end
        S_DEB: begin
          if (!pen_detect) st_n = S_IDLE;
          else if (tick) begin
            if (ph == '0) begin
              pen_n = 1'b1;  miss_n = '0;  st_n = S_SETX;
              ph_n  = PHW'(settle_ticks - 1'b1);
              per_n = period_ticks - 1'b1;
            end else ph_n = ph - 1'b1;
          end
        end
        default: begin
          if (!pen_detect) begin
            st_n = S_IDLE;  pen_n = 1'b0;
          end else begin
            case (st)
              S_SETX, S_SETY: if (tick) begin
                if (ph == '0) st_n = (st == S_SETX) ? S_CNVX : S_CNVY;
                else          ph_n = ph - 1'b1;
              end
              S_CNVX: if (avg_done) begin
                xa_n = avg_mean;  st_n = S_SETY;
                ph_n = PHW'(settle_ticks - 1'b1);
              end
              S_CNVY: if (avg_done) begin
                st_n = S_WAIT;
                if (!bad) begin
                  sx_n = xa_q;  sy_n = avg_mean;  sv_n = 1'b1;  miss_n = '0;
                end else if ((touch_lim != '0) &&
                             ({1'b0, miss_q} + 1'b1 == {1'b0, touch_lim})) begin
                  st_n = S_IDLE;  pen_n = 1'b0;  miss_n = '0;
                end else miss_n = miss_q + 1'b1;
              end
              S_WAIT: if (per == '0) begin
                st_n  = S_SETX;
                ph_n  = PHW'(settle_ticks - 1'b1);
                per_n = period_ticks - 1'b1;
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st <= S_IDLE;  ph <= '0;  per <= '0;
      pen_q <= 1'b0;  sv_q <= 1'b0;
      sx_q <= '0;  sy_q <= '0;  xa_q <= '0;  miss_q <= '0;
    end else begin
      st <= st_n;  ph <= ph_n;  per <= per_n;
      pen_q <= pen_n;  sv_q <= sv_n;
      sx_q <= sx_n;  sy_q <= sy_n;  xa_q <= xa_n;  miss_q <= miss_n;
    end
  end

  assign adc_req      = converting;
  assign drive_x      = (st == S_SETX) || (st == S_CNVX);
  assign drive_y      = (st == S_SETY) || (st == S_CNVY);
  assign pen_down     = pen_q;
  assign sample_valid = sv_q;
  assign sample_x     = sx_q;
  assign sample_y     = sy_q;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_q |-> (!pen_down && !sample_valid));
  assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (!rst_q)
    !cfg_enable |=> (!pen_down && !adc_req));
  assert_debounce_held_R3: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(pen_down) |-> $past(pen_detect));
  assert_pen_drop_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (pen_down && !pen_detect) |=> !pen_down);
  assert_req_needs_pen_R4: assert property (@(posedge clk) disable iff (!rst_q)
    adc_req |-> pen_down);
  assert_axis_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_q)
    !(drive_x && drive_y));
  assert_y_after_x_R6: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(drive_y) |-> $past(drive_x && adc_req));
  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_q)
    sample_valid |=> !sample_valid);
endmodule

// File: tb/tb_touch_scan_seq.sv
`timescale 1ns/1ps
module tb_touch_scan_seq;
  import tss_pkg::*;

  localparam int PU = 32;
  localparam int DU = 4;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic        en, pen, adc_valid;
  logic [31:0] timing;
  logic [3:0]  avg;
  logic [15:0] adc_data;
  logic        adc_req, drive_x, drive_y, pen_down, sample_valid;
  logic [15:0] sample_x, sample_y;

  int n_run = 0, n_fail = 0;
  int xbase = 0, xstep = 0, ybase = 0, ystep = 0;
  int xsum = 0, ysum = 0, xi = 0, yi = 0;

  touch_scan_seq #(.TICK_DIV(1), .PERIOD_UNIT(PU), .DEB_UNIT(DU)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(en), .cfg_timing(timing),
    .cfg_avg_log2(avg), .pen_detect(pen), .adc_req(adc_req),
    .adc_valid(adc_valid), .adc_data(adc_data), .drive_x(drive_x),
    .drive_y(drive_y), .pen_down(pen_down), .sample_valid(sample_valid),
    .sample_x(sample_x), .sample_y(sample_y)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int settle_exp(input int code);
    int c;
    c = (code > 11) ? 11 : code;
    return (c == 0) ? 8 : (10 << (c - 1));
  endfunction

  // ADC model: answers every request cycle with a ramp per axis
  initial begin
    adc_valid = 1'b0;
    adc_data  = '0;
    forever begin
      @(negedge clk);
      if (adc_req) begin
        adc_valid = 1'b1;
        if (drive_x) begin
          adc_data = 16'(xbase + xi * xstep);  xsum += int'(adc_data);  xi++;
        end else begin
          adc_data = 16'(ybase + yi * ystep);  ysum += int'(adc_data);  yi++;
        end
      end else begin
        adc_valid = 1'b0;
        if (drive_x) begin xsum = 0; xi = 0; end
        if (drive_y) begin ysum = 0; yi = 0; end
      end
    end
  end

  task automatic touch_on(output int lat);
    pen = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!pen_down && lat < 20000);
  endtask

  task automatic touch_off();
    pen = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_sv(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!sample_valid && k < 30000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lat, k, seen, starts, prevx;
    rst_n = 1'b0;  en = 1'b0;  pen = 1'b0;
    timing = TIMING_DEFAULT;  avg = AVG_DEFAULT;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 pen_down", int'(pen_down), 0);
    chk("R1 sample_valid", int'(sample_valid), 0);
    chk("R1 adc_req", int'(adc_req), 0);
    chk("R1 drives", int'(drive_x | drive_y), 0);

    // R2 disabled controller ignores the pen
    pen = 1'b1;  seen = 0;
    repeat (60) begin @(negedge clk); seen |= int'(pen_down | adc_req); end
    chk("R2 disabled", seen, 0);
    pen = 1'b0;  en = 1'b1;
    repeat (3) @(negedge clk);

    // R3 debounce sweep
    foreach (timing[i]) ;
    for (int d = 0; d < 5; d++) begin
      int dv;
      dv = (d == 4) ? 40 : ((1 << d) - 1);
      timing = {8'd5, 8'(dv), 8'd0, 8'd0};  avg = 0;
      touch_on(lat);
      chk("R3 debounce latency", lat, dv * DU + 2);
      touch_off();
    end
    timing = {8'd5, 8'd3, 8'd0, 8'd0};
    pen = 1'b1;  seen = 0;
    repeat (3 * DU + 1) begin @(negedge clk); seen |= int'(pen_down); end
    pen = 1'b0;
    repeat (40) begin @(negedge clk); seen |= int'(pen_down); end
    chk("R3 short glitch", seen, 0);

    // R5 / R6 settling per code, X first then Y
    for (int c = 0; c < 6; c++) begin
      int code;
      code = (c == 5) ? 12 : c;
      timing = {8'd5, 8'd0, 8'(code), 8'd0};  avg = 0;
      touch_on(lat);
      chk("R6 x first", int'(drive_x), 1);
      k = 0;
      while (drive_x && !adc_req) begin k++; @(negedge clk); end
      chk("R5 x settle", k, settle_exp(code));
      k = 0;
      while (!drive_y && k < 30000) begin k++; @(negedge clk); end
      k = 0;
      while (drive_y && !adc_req) begin k++; @(negedge clk); end
      chk("R5 y settle", k, settle_exp(code));
      touch_off();
    end

    // R7 averaging sweep
    for (int n = 0; n < 10; n++) begin
      int nsel, ne;
      nsel = (n == 9) ? 11 : n;
      ne   = (nsel > 8) ? 8 : nsel;
      timing = {8'd1, 8'd0, 8'd0, 8'd0};  avg = 4'(nsel);
      xbase = 100 + n * 37;  xstep = 13 + n;
      ybase = 30000 - n * 11;  ystep = 117;
      touch_on(lat);
      wait_sv(k);
      chk("R7 x mean", int'(sample_x), xsum >> ne);
      chk("R7 y mean", int'(sample_y), ysum >> ne);
      touch_off();
    end

    // R8 period spacing
    for (int t = 0; t < 5; t++) begin
      int pf, sel, exp;
      pf  = (t == 0) ? 5 : (t == 1) ? 1 : (t == 2) ? 0 : 5;
      sel = (t == 3) ? 8 : 0;
      timing = {8'(pf), 8'd0, 8'd0, 8'd0};  avg = 4'(sel);
      exp = ((pf == 0) ? 256 : pf) * PU;
      if (2 * 8 + 2 * (1 << sel) + 1 > exp) exp = 2 * 8 + 2 * (1 << sel) + 1;
      if (t == 4) begin
        timing = TIMING_DEFAULT;  avg = AVG_DEFAULT;
        exp = 2 * settle_exp(7) + 2 * 32 + 1;
      end
      touch_on(lat);
      wait_sv(k);
      wait_sv(k);
      chk("R8 sample spacing", k, exp);
      touch_off();
    end

    // R9 invalid samples and touch timeout
    xbase = 65535;  xstep = 0;
    timing = {8'd1, 8'd0, 8'd0, 8'd3};  avg = 2;
    touch_on(lat);
    seen = 0;  starts = 0;  prevx = 0;  k = 0;
    while (pen_down && k < 5000) begin
      if (drive_x && !prevx) starts++;
      prevx = int'(drive_x);
      seen |= int'(sample_valid);
      k++;
      @(negedge clk);
    end
    chk("R9 timeout drops pen", int'(pen_down), 0);
    chk("R9 samples before timeout", starts, 3);
    chk("R9 invalid not presented", seen, 0);
    touch_off();
    timing = {8'd1, 8'd0, 8'd0, 8'd0};
    touch_on(lat);
    seen = 0;  k = 0;
    repeat (1500) begin @(negedge clk); seen |= int'(sample_valid); k |= int'(!pen_down); end
    chk("R9 zero timeout keeps pen", k, 0);
    chk("R9 zero timeout no strobe", seen, 0);
    touch_off();

    // R4 pen lifted during a conversion
    xbase = 500;  xstep = 3;
    timing = {8'd5, 8'd0, 8'd1, 8'd0};  avg = 4;
    touch_on(lat);
    while (!adc_req) @(negedge clk);
    repeat (3) @(negedge clk);
    pen = 1'b0;
    @(negedge clk);
    chk("R4 pen_down low", int'(pen_down), 0);
    chk("R4 adc_req low", int'(adc_req), 0);
    chk("R4 drive low", int'(drive_x | drive_y), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule